// File: doc/BRIEF.md
# Striped Parity Memory Engine

This block sits between a cache-line memory port and five memory module ports. Every line written is cut into four equal blocks. Each block goes to its own data module, and a fifth module receives the XOR parity of the four blocks. Because of that redundancy, any one module can be pulled, disabled or found faulty without losing data.

On a read, the engine issues the command to every present module. When the modules answer together, it assembles the line. A module is left out when its presence bit is clear or when it flags its own block as bad. If exactly one data module is left out, that block is rebuilt from the three remaining data blocks and the parity block. If only the parity module is left out, the data blocks are used as they are. With nothing left out, the parity is checked and a mismatch is reported, but the data is not altered. With two or more modules left out, the line cannot be recovered: the response carries an uncorrectable flag and zeroed, invalid data.

Commands and responses each pass through one register stage. The block size, the number of data modules and the address width are parameters. A generate option can remove the response register.

Top module: `stripe_parity_mem`

## Requirements
- R1: A write request drives, one cycle later, module i's block of `mod_wr_data` (bits [64i+63:64i]) with `wr_line` bits [64i+63:64i] for i = 0..3, and drives `mod_addr` with `wr_addr`.
- R2: The block written to module 4 (bits [319:256]) equals the XOR of the four data blocks, so the five written blocks XOR to zero.
- R3: Write enables go only to modules whose `mod_present` bit is 1. When a single data module is absent, the parity module is still written.
- R4: A read request sets `mod_rd_en` to `mod_present` one cycle later. When a write and a read are requested in the same cycle, the write is issued and the read is dropped (`mod_rd_en` = 0).
- R5: With all five modules present and none flagged bad, the response line is the four data blocks unchanged and `rsp_ok` is 1. `rsp_parity_err` is 1 exactly when the five blocks XOR to a nonzero value.
- R6: With exactly one data module excluded (absent or flagged bad), that block of `rsp_line` equals the XOR of the other three data blocks and the parity block. `rsp_degraded` = 1, `rsp_ok` = 1 and `rsp_parity_err` = 0.
- R7: With only the parity module excluded, `rsp_line` is the four data blocks, `rsp_degraded` = 1 and `rsp_parity_err` = 0.
- R8: The returned data and the bad flag of an absent module have no effect on any response output.
- R9: With two or more modules excluded, `rsp_uncorr` = 1, `rsp_ok` = 0, `rsp_line` = 0 and `rsp_degraded` = 0.
- R10: `rsp_valid` rises exactly one cycle after `mod_rsp_valid`. At most one of `rsp_uncorr`, `rsp_degraded` and `rsp_parity_err` is set, and all response outputs are 0 while `rsp_valid` is 0.
- R11: During reset all module enables, `rsp_valid` and the response flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_present | input | 5 | Per-module present mask, bit 4 is the parity module |
| wr_valid | input | 1 | Line write request |
| wr_addr | input | 32 | Write line address |
| wr_line | input | 256 | Line to write |
| rd_valid | input | 1 | Line read request |
| rd_addr | input | 32 | Read line address |
| mod_wr_en | output | 5 | Per-module write strobe |
| mod_rd_en | output | 5 | Per-module read strobe |
| mod_addr | output | 32 | Address shared by all modules |
| mod_wr_data | output | 320 | Five 64-bit blocks, block i at bits [64i+63:64i] |
| mod_rsp_valid | input | 1 | Modules return read data |
| mod_rsp_data | input | 320 | Five returned blocks, same layout as mod_wr_data |
| mod_rsp_bad | input | 5 | Per-module block check failure |
| rsp_valid | output | 1 | Read response strobe |
| rsp_line | output | 256 | Assembled line |
| rsp_ok | output | 1 | Line data is valid |
| rsp_degraded | output | 1 | One module was excluded and the line was still delivered |
| rsp_parity_err | output | 1 | Parity mismatch with all modules present |
| rsp_uncorr | output | 1 | Two or more modules excluded, line lost |

## Verification
Module commands and strobes are due one rising edge after the request, and the response outputs are due one rising edge after `mod_rsp_valid`. The bench drives every stimulus on a falling edge and checks on the next falling edge, so exactly one rising edge falls between the drive and the check. It then checks once more a cycle later that the strobes have dropped back to zero. Expected lines and flags come from a bench function that counts the excluded modules and rebuilds blocks on its own terms.

// File: rtl/spm_pkg.sv
package spm_pkg;
   // classification of a read response by number of excluded modules
   typedef enum logic [1:0] {
      RD_CLEAN    = 2'd0,
      RD_DEGRADED = 2'd1,
      RD_LOST     = 2'd2
   } rd_class_e;

   function automatic rd_class_e classify(input int excluded);
      if (excluded == 0)      return RD_CLEAN;
      else if (excluded == 1) return RD_DEGRADED;
      else                    return RD_LOST;
   endfunction
endpackage

// File: rtl/spm_xor_reduce.sv
module spm_xor_reduce #(
   parameter int N = 4,
   parameter int W = 64
) (
   input  logic [N*W-1:0] din,
   output logic [W-1:0]   dout
);
   initial begin
      assert (N >= 1 && W >= 1) else $error("spm_xor_reduce: bad size");
   end

   always_comb begin
      dout = '0;
      for (int i = 0; i < N; i++) dout ^= din[i*W +: W];
   end
endmodule

// File: rtl/spm_write_path.sv
module spm_write_path #(
   parameter int BLK_W    = 64,
   parameter int NUM_DATA = 4,
   parameter int ADDR_W   = 32,
   localparam int NUM_MOD = NUM_DATA + 1,
   localparam int LINE_W  = BLK_W * NUM_DATA,
   localparam int BUS_W   = BLK_W * NUM_MOD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MOD-1:0] present,
   input  logic               wr_valid,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [LINE_W-1:0]  wr_line,
   input  logic               rd_valid,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [NUM_MOD-1:0] mod_wr_en,
   output logic [NUM_MOD-1:0] mod_rd_en,
   output logic [ADDR_W-1:0]  mod_addr,
   output logic [BUS_W-1:0]   mod_wr_data
);
   logic [BLK_W-1:0] parity_blk;

   spm_xor_reduce #(.N(NUM_DATA), .W(BLK_W)) u_par (
      .din  (wr_line),
      .dout (parity_blk)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_wr_en   <= '0;
         mod_rd_en   <= '0;
         mod_addr    <= '0;
         mod_wr_data <= '0;
      end else begin
         mod_wr_en <= wr_valid ? present : '0;
         mod_rd_en <= (rd_valid && !wr_valid) ? present : '0;
         if (wr_valid) begin
            mod_addr    <= wr_addr;
            mod_wr_data <= {parity_blk, wr_line};
         end else if (rd_valid) begin
            mod_addr <= rd_addr;
         end
      end
   end

   // R3: no strobe reaches a module that was absent when the request came in
   p_no_absent_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid || rd_valid) |=> (((mod_wr_en | mod_rd_en) & ~$past(present)) == '0));

   // R4: a write in the same cycle suppresses the read
   p_wr_over_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> (mod_rd_en == '0));

   // R4: an accepted read strobes the present modules
   p_rd_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !wr_valid) |=> (mod_rd_en == $past(present)));
endmodule

// File: rtl/spm_read_path.sv
module spm_read_path #(
   parameter int BLK_W    = 64,
   parameter int NUM_DATA = 4,
   parameter bit PIPE_RD  = 1'b1,
   localparam int NUM_MOD = NUM_DATA + 1,
   localparam int LINE_W  = BLK_W * NUM_DATA,
   localparam int BUS_W   = BLK_W * NUM_MOD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MOD-1:0] present,
   input  logic               in_valid,
   input  logic [BUS_W-1:0]   in_data,
   input  logic [NUM_MOD-1:0] in_bad,
   output logic               rsp_valid,
   output logic [LINE_W-1:0]  rsp_line,
   output logic               rsp_ok,
   output logic               rsp_degraded,
   output logic               rsp_parity_err,
   output logic               rsp_uncorr
);
   import spm_pkg::*;

   logic [NUM_MOD-1:0] excl;
   logic [BUS_W-1:0]   kept;
   logic [BLK_W-1:0]   kept_sum;
   rd_class_e          cls;
   logic [LINE_W-1:0]  line_c;
   logic               ok_c, deg_c, perr_c, unc_c;

   assign excl = ~present | in_bad;

   // excluded blocks are forced to zero so their content never matters
   for (genvar i = 0; i < NUM_MOD; i++) begin : g_keep
      assign kept[i*BLK_W +: BLK_W] = excl[i] ? '0 : in_data[i*BLK_W +: BLK_W];
   end

   spm_xor_reduce #(.N(NUM_MOD), .W(BLK_W)) u_sum (
      .din  (kept),
      .dout (kept_sum)
   );

   always_comb begin
      cls    = classify($countones(excl));
      line_c = '0;
      for (int j = 0; j < NUM_DATA; j++)
         line_c[j*BLK_W +: BLK_W] = excl[j] ? kept_sum : kept[j*BLK_W +: BLK_W];
      ok_c   = (cls != RD_LOST);
      deg_c  = (cls == RD_DEGRADED);
      perr_c = (cls == RD_CLEAN) && (kept_sum != '0);
      unc_c  = (cls == RD_LOST);
      if (unc_c) line_c = '0;
   end

   if (PIPE_RD) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_line       <= '0;
            rsp_ok         <= 1'b0;
            rsp_degraded   <= 1'b0;
            rsp_parity_err <= 1'b0;
            rsp_uncorr     <= 1'b0;
         end else begin
            rsp_valid      <= in_valid;
            rsp_line       <= in_valid ? line_c : '0;
            rsp_ok         <= in_valid && ok_c;
            rsp_degraded   <= in_valid && deg_c;
            rsp_parity_err <= in_valid && perr_c;
            rsp_uncorr     <= in_valid && unc_c;
         end
      end

      // R10: response comes exactly one cycle after the module answer
      p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> rsp_valid);
      p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !rsp_valid);
   end else begin : g_comb
      assign rsp_valid      = in_valid;
      assign rsp_line       = in_valid ? line_c : '0;
      assign rsp_ok         = in_valid && ok_c;
      assign rsp_degraded   = in_valid && deg_c;
      assign rsp_parity_err = in_valid && perr_c;
      assign rsp_uncorr     = in_valid && unc_c;
   end

   // R10: at most one status flag per response
   p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_uncorr, rsp_degraded, rsp_parity_err}));

   // R9: a lost line carries no data and is never marked valid
   p_lost_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_uncorr |-> (!rsp_ok && rsp_line == '0));

   // R10: valid data and the uncorrectable flag are exclusive on a response
   p_ok_vs_unc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ok != rsp_uncorr));
endmodule

// File: rtl/stripe_parity_mem.sv
module stripe_parity_mem #(
   parameter int BLK_W    = 64,
   parameter int NUM_DATA = 4,
   parameter int ADDR_W   = 32,
   parameter bit PIPE_RD  = 1'b1,
   localparam int NUM_MOD = NUM_DATA + 1,
   localparam int LINE_W  = BLK_W * NUM_DATA,
   localparam int BUS_W   = BLK_W * NUM_MOD
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MOD-1:0] mod_present,
   input  logic               wr_valid,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [LINE_W-1:0]  wr_line,
   input  logic               rd_valid,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [NUM_MOD-1:0] mod_wr_en,
   output logic [NUM_MOD-1:0] mod_rd_en,
   output logic [ADDR_W-1:0]  mod_addr,
   output logic [BUS_W-1:0]   mod_wr_data,
   input  logic               mod_rsp_valid,
   input  logic [BUS_W-1:0]   mod_rsp_data,
   input  logic [NUM_MOD-1:0] mod_rsp_bad,
   output logic               rsp_valid,
   output logic [LINE_W-1:0]  rsp_line,
   output logic               rsp_ok,
   output logic               rsp_degraded,
   output logic               rsp_parity_err,
   output logic               rsp_uncorr
);
   initial begin
      assert (NUM_DATA >= 2) else $error("stripe_parity_mem: NUM_DATA must be at least 2");
      assert (BLK_W >= 1)    else $error("stripe_parity_mem: BLK_W must be positive");
      assert (ADDR_W >= 1)   else $error("stripe_parity_mem: ADDR_W must be positive");
   end

   spm_write_path #(.BLK_W(BLK_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .present     (mod_present),
      .wr_valid    (wr_valid),
      .wr_addr     (wr_addr),
      .wr_line     (wr_line),
      .rd_valid    (rd_valid),
      .rd_addr     (rd_addr),
      .mod_wr_en   (mod_wr_en),
      .mod_rd_en   (mod_rd_en),
      .mod_addr    (mod_addr),
      .mod_wr_data (mod_wr_data)
   );

   spm_read_path #(.BLK_W(BLK_W), .NUM_DATA(NUM_DATA), .PIPE_RD(PIPE_RD)) u_rd (
      .clk            (clk),
      .rst_n          (rst_n),
      .present        (mod_present),
      .in_valid       (mod_rsp_valid),
      .in_data        (mod_rsp_data),
      .in_bad         (mod_rsp_bad),
      .rsp_valid      (rsp_valid),
      .rsp_line       (rsp_line),
      .rsp_ok         (rsp_ok),
      .rsp_degraded   (rsp_degraded),
      .rsp_parity_err (rsp_parity_err),
      .rsp_uncorr     (rsp_uncorr)
   );

   // R2: the five blocks leaving on any write XOR to zero
   logic [BLK_W-1:0] wr_sum;
   spm_xor_reduce #(.N(NUM_MOD), .W(BLK_W)) u_wchk (
      .din  (mod_wr_data),
      .dout (wr_sum)
   );

   p_stripe_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_wr_en != '0) |-> (wr_sum == '0));

   // R1: the written line lands unchanged in the data blocks
   p_line_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> (mod_wr_data[LINE_W-1:0] == $past(wr_line)));
endmodule

// File: tb/stripe_parity_mem_test.sv
`timescale 1ns/1ps
module stripe_parity_mem_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [4:0]   mod_present = 5'h1F;
   logic         wr_valid = 1'b0;
   logic [31:0]  wr_addr = '0;
   logic [255:0] wr_line = '0;
   logic         rd_valid = 1'b0;
   logic [31:0]  rd_addr = '0;
   logic [4:0]   mod_wr_en, mod_rd_en;
   logic [31:0]  mod_addr;
   logic [319:0] mod_wr_data;
   logic         mod_rsp_valid = 1'b0;
   logic [319:0] mod_rsp_data = '0;
   logic [4:0]   mod_rsp_bad = '0;
   logic         rsp_valid, rsp_ok, rsp_degraded, rsp_parity_err, rsp_uncorr;
   logic [255:0] rsp_line;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   stripe_parity_mem uut (
      .clk(clk), .rst_n(rst_n), .mod_present(mod_present),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_line(wr_line),
      .rd_valid(rd_valid), .rd_addr(rd_addr),
      .mod_wr_en(mod_wr_en), .mod_rd_en(mod_rd_en), .mod_addr(mod_addr),
      .mod_wr_data(mod_wr_data), .mod_rsp_valid(mod_rsp_valid),
      .mod_rsp_data(mod_rsp_data), .mod_rsp_bad(mod_rsp_bad),
      .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_ok(rsp_ok),
      .rsp_degraded(rsp_degraded), .rsp_parity_err(rsp_parity_err),
      .rsp_uncorr(rsp_uncorr)
   );

   task automatic chk(input string req, input logic [319:0] act, input logic [319:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] blk(input logic [319:0] b, input int i);
      return b[i*64 +: 64];
   endfunction

   function automatic logic [319:0] rand_bus();
      logic [319:0] v;
      for (int i = 0; i < 10; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   // expected {ok, degraded, parity_err, uncorr} and line, per requirements
   function automatic logic [259:0] model(input logic [319:0] d, input logic [4:0] pres,
                                          input logic [4:0] bad);
      int          n_out = 0;
      int          lost_idx = -1;
      logic [63:0] s = '0;
      logic [255:0] ln;
      for (int i = 0; i < 5; i++) begin
         if (!pres[i] || bad[i]) begin n_out++; lost_idx = i; end
      end
      for (int i = 0; i < 4; i++) ln[i*64 +: 64] = blk(d, i);
      if (n_out >= 2) return {4'b0001, 256'h0};
      if (n_out == 1) begin
         if (lost_idx < 4) begin
            s = blk(d, 4);
            for (int i = 0; i < 4; i++) if (i != lost_idx) s ^= blk(d, i);
            ln[lost_idx*64 +: 64] = s;
         end
         return {4'b1100, ln};
      end
      for (int i = 0; i < 5; i++) s ^= blk(d, i);
      return {1'b1, 1'b0, (s != 0), 1'b0, ln};
   endfunction

   function automatic logic [319:0] with_parity(input logic [255:0] ln);
      logic [63:0] p = '0;
      for (int i = 0; i < 4; i++) p ^= ln[i*64 +: 64];
      return {p, ln};
   endfunction

   task automatic do_write(input logic [31:0] a, input logic [255:0] ln, input string tag);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_line = ln;
      @(negedge clk);
      wr_valid = 1'b0;
      chk({tag, " R3 wr_en"}, 320'(mod_wr_en), 320'(mod_present));
      chk({tag, " R1 addr"}, 320'(mod_addr), 320'(a));
      chk({tag, " R1/R2 data"}, mod_wr_data, with_parity(ln));
      @(negedge clk);
      chk({tag, " R3 wr_en drop"}, 320'(mod_wr_en), 320'(0));
   endtask

   task automatic do_resp(input logic [319:0] d, input logic [4:0] bad, input string tag);
      logic [259:0] e;
      e = model(d, mod_present, bad);
      @(negedge clk);
      mod_rsp_valid = 1'b1; mod_rsp_data = d; mod_rsp_bad = bad;
      @(negedge clk);
      mod_rsp_valid = 1'b0; mod_rsp_data = rand_bus(); mod_rsp_bad = 5'(($urandom));
      chk({tag, " R10 valid"}, 320'(rsp_valid), 320'(1));
      chk({tag, " R5/R6/R7/R9 line"}, 320'(rsp_line), 320'(e[255:0]));
      chk({tag, " R5/R6/R9 flags ok,deg,perr,unc"},
          320'({rsp_ok, rsp_degraded, rsp_parity_err, rsp_uncorr}), 320'(e[259:256]));
      @(negedge clk);
      chk({tag, " R10 idle"}, 320'({rsp_valid, rsp_ok, rsp_degraded, rsp_parity_err, rsp_uncorr, rsp_line}), 320'(0));
   endtask

   initial begin
      #(100000 * 8);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [319:0] d;
      logic [255:0] ln;
      void'($urandom(32'd20771));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset enables", 320'({mod_wr_en, mod_rd_en}), 320'(0));
      chk("R11 reset response", 320'({rsp_valid, rsp_ok, rsp_degraded, rsp_parity_err, rsp_uncorr}), 320'(0));
      rst_n = 1'b1;

      // R1 R2 directed writes
      ln = {64'h4444_4444_4444_4444, 64'h3333_3333_3333_3333,
            64'h2222_2222_2222_2222, 64'h1111_1111_1111_1111};
      do_write(32'h0000_1000, ln, "R1 pattern");
      do_write(32'hFFFF_FFC0, {256{1'b1}}, "R2 ones");
      // R3: data module 2 absent, parity still written
      mod_present = 5'b11011;
      do_write(32'h40, rand_bus()[255:0], "R3 degraded write");
      mod_present = 5'h1F;

      // R4 read issue, and write priority
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = 32'h0000_2200;
      mod_present = 5'b10111;
      @(negedge clk);
      rd_valid = 1'b0;
      chk("R4 rd_en", 320'(mod_rd_en), 320'(5'b10111));
      chk("R4 rd addr", 320'(mod_addr), 320'(32'h2200));
      chk("R4 no write on read", 320'(mod_wr_en), 320'(0));
      mod_present = 5'h1F;
      @(negedge clk);
      wr_valid = 1'b1; rd_valid = 1'b1; wr_addr = 32'h80; rd_addr = 32'h99;
      @(negedge clk);
      wr_valid = 1'b0; rd_valid = 1'b0;
      chk("R4 collision rd dropped", 320'(mod_rd_en), 320'(0));
      chk("R4 collision wr issued", 320'({mod_wr_en, mod_addr}), 320'({5'h1F, 32'h80}));

      // R5 clean and parity error
      d = with_parity(rand_bus()[255:0]);
      do_resp(d, 5'b0, "R5 clean");
      d[300] = ~d[300];
      do_resp(d, 5'b0, "R5 parity mismatch");
      // R6 each data module flagged bad, garbage in its slot
      for (int j = 0; j < 4; j++) begin
         d = with_parity(rand_bus()[255:0]);
         d[j*64 +: 64] = ~d[j*64 +: 64];
         do_resp(d, 5'(1 << j), "R6 rebuild");
      end
      // R7 parity module bad
      d = with_parity(rand_bus()[255:0]);
      d[319:256] = 64'hDEAD_BEEF_0000_0001;
      do_resp(d, 5'b10000, "R7 parity lost");
      // R8 absent module: contents and bad flag ignored
      mod_present = 5'b11110;
      d = with_parity(rand_bus()[255:0]);
      d[63:0] = 64'h0123_4567_89AB_CDEF;
      do_resp(d, 5'b00001, "R8 absent bad flag");
      d[63:0] = 64'hFEDC_BA98_7654_3210;
      do_resp(d, 5'b00000, "R8 absent other content");
      // R9 two excluded (one absent plus one bad)
      do_resp(d, 5'b01000, "R9 two out");
      mod_present = 5'h1F;
      do_resp(d, 5'b00110, "R9 two bad");

      // random mix
      for (int k = 0; k < 300; k++) begin
         logic [4:0] bad;
         mod_present = ($urandom % 4 == 0) ? 5'h1F & ~(5'(1) << ($urandom % 5)) : 5'h1F;
         if (k % 3 == 0) begin
            do_write($urandom, rand_bus()[255:0], "R1/R2/R3 random write");
         end else begin
            d = ($urandom % 5 == 0) ? rand_bus() : with_parity(rand_bus()[255:0]);
            bad = ($urandom % 3 == 0) ? 5'($urandom) : 5'(0);
            do_resp(d, bad, "R5-R9 random read");
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule